// File: doc/BRIEF.md
# Receive DMA Transaction Watermark Controller

This block watches the completed OUT transactions on the endpoints served by several receive DMA channels (three by default) of a USB function. Each channel counts down a programmable number of transactions. When the count runs out it sets a count interrupt flag and starts the next period from the programmed value. Software can also mark a channel as terminal. In that case the watermark ends the transfer: the channel sets an end-of-transfer flag as well, stops counting, and drives a NAK-force line for its endpoint. The line stays high until software re-enables the channel.

Each channel is a two-state machine. `ST_RUN` counts transactions. `ST_HALT` ignores transactions and forces NAK. There are two transitions. `T_EOT` goes from `ST_RUN` to `ST_HALT` when a transaction arrives at a count of zero with the stop bit set. `T_REARM` goes from `ST_HALT` to `ST_RUN` on the channel's re-enable strobe. Software reaches each channel's 16-bit control register through a shared write port with a channel select and a combinational read port with its own select.

Top module: `rxwm_ctrl`

## Requirements
- R1: The control register layout is: bit 15 is the stop flag, bits 14..8 always read 0 and ignore writes, and bits 7..0 hold the count field.
- R2: A programmed count value N gives a watermark of N+1 transactions. N=0 raises the count interrupt on every transaction and N=255 raises it on every 256th.
- R3: When a transaction arrives in `ST_RUN` with the remaining count at zero, the count flag is set on the next clock and the remaining count reloads from the programmed value. With the stop flag clear, counting continues.
- R4: If the stop flag is set when the watermark is reached, the count flag and the end-of-transfer flag are both set on the same clock (`T_EOT`).
- R5: In `ST_HALT` the channel's NAK-force output is high. In `ST_RUN` it is low.
- R6: A re-enable strobe in `ST_HALT` returns the channel to `ST_RUN` (`T_REARM`) and reloads the remaining count from the programmed value. In `ST_RUN` the strobe has no effect.
- R7: The count field reads back the number of transactions still remaining before the count interrupt, not the programmed value. A register write loads that remaining count with the written count field.
- R8: An asynchronous local reset (rst_n low) or a synchronous bus reset (bus_rst high) returns every channel to `ST_RUN` with the stop flag, remaining count, programmed count and both flags cleared.
- R9: Each flag is sticky and is cleared by its write-one-to-clear strobe. A set in the same cycle wins over a clear.
- R10: Transaction pulses in `ST_HALT` are ignored: the remaining count and the flags do not change.
- R11: Channels are independent. Stimulus addressed to one channel never changes another channel's outputs or register.
- R12: A register write in the same cycle as a transaction pulse on that channel takes priority. The written value is loaded and the pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous local reset, active low |
| bus_rst | input | 1 | Synchronous USB bus reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Channel selected for the write |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 2 | Channel selected for the read |
| reg_rdata | output | 16 | Read data: {stop, 7'b0, remaining count} |
| out_done | input | 3 | One-cycle pulse per accepted OUT transaction, one bit per channel |
| rearm | input | 3 | Re-enable strobe per channel |
| clr_cnt | input | 3 | Write-one-to-clear for the count flags |
| clr_eot | input | 3 | Write-one-to-clear for the end-of-transfer flags |
| cnt_irq | output | 3 | Sticky count interrupt flags |
| eot_irq | output | 3 | Sticky end-of-transfer interrupt flags |
| nak_force | output | 3 | Force NAK on the channel's endpoint |

## Verification
The checker tests on every cycle the properties that relate the flags and states to one another. A new end-of-transfer flag comes with the count flag and NAK-force. A halted channel stays halted until a re-enable or a reset. A count flag rises only after a transaction pulse. Either reset clears every output. The exact watermark period for values such as 0 and 255, the read-back of the remaining count, the reload on re-enable, the write-over-pulse priority and the independence of the channels depend on counted histories. Only the bench's scenarios show these, by comparing the outputs with its own model on every clock.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
    localparam int REG_W    = 16;
    localparam int CNT_W    = 8;
    localparam int STOP_BIT = 15;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } chan_state_t;
endpackage

// File: rtl/rxwm_chan.sv
module rxwm_chan
    import rxwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             wr_stop,
    input  logic             pulse,
    input  logic             rearm,
    input  logic             clr_cnt,
    input  logic             clr_eot,
    output logic [REG_W-1:0] rdata,
    output logic             cnt_irq,
    output logic             eot_irq,
    output logic             nak_force
);
    localparam int PAD_W = STOP_BIT - CNT_W;

    chan_state_t      state_q, state_d;
    logic [CNT_W-1:0] prog_q, remain_q;
    logic             stop_q;
    logic             cnt_q, eot_q;

    logic hit;
    logic take_pulse;
    logic t_eot, t_rearm;

    // a counted transaction at zero remaining reaches the watermark
    assign take_pulse = (state_q == ST_RUN) && pulse && !wr;
    assign hit        = take_pulse && (remain_q == '0);
    assign t_eot      = hit && stop_q;
    assign t_rearm    = (state_q == ST_HALT) && rearm;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (t_eot)   state_d = ST_HALT;
            ST_HALT: if (t_rearm) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state_q <= ST_RUN;
        else if (bus_rst) state_q <= ST_RUN;
        else              state_q <= state_d;
    end

    // count datapath and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q   <= '0;
            remain_q <= '0;
            stop_q   <= 1'b0;
            cnt_q    <= 1'b0;
            eot_q    <= 1'b0;
        end else if (bus_rst) begin
            prog_q   <= '0;
            remain_q <= '0;
            stop_q   <= 1'b0;
            cnt_q    <= 1'b0;
            eot_q    <= 1'b0;
        end else begin
            if (wr) begin
                prog_q   <= wr_count;
                remain_q <= wr_count;
                stop_q   <= wr_stop;
            end else if (t_rearm) begin
                remain_q <= prog_q;
            end else if (take_pulse) begin
                remain_q <= hit ? prog_q : remain_q - 1'b1;
            end
            cnt_q <= hit   || (cnt_q && !clr_cnt);
            eot_q <= t_eot || (eot_q && !clr_eot);
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            ST_RUN:  nak_force = 1'b0;
            ST_HALT: nak_force = 1'b1;
            default: nak_force = 1'b0;
        endcase
        cnt_irq = cnt_q;
        eot_irq = eot_q;
        rdata   = {stop_q, {PAD_W{1'b0}}, remain_q};
    end
endmodule

// File: rtl/rxwm_rdmux.sv
module rxwm_rdmux
    import rxwm_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int SEL_W = 2
) (
    input  logic [NCH*REG_W-1:0] regs,
    input  logic [SEL_W-1:0]     sel,
    output logic [REG_W-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == SEL_W'(i)) rdata = regs[i*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/rxwm_ctrl.sv
module rxwm_ctrl
    import rxwm_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             reg_wr,
    input  logic [SEL_W-1:0] reg_wsel,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic [SEL_W-1:0] reg_rsel,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NCH-1:0]   out_done,
    input  logic [NCH-1:0]   rearm,
    input  logic [NCH-1:0]   clr_cnt,
    input  logic [NCH-1:0]   clr_eot,
    output logic [NCH-1:0]   cnt_irq,
    output logic [NCH-1:0]   eot_irq,
    output logic [NCH-1:0]   nak_force
);
    logic [NCH*REG_W-1:0] all_regs;
    logic                 unused_pad;

    // reserved write bits are dropped here
    assign unused_pad = ^reg_wdata[STOP_BIT-1:CNT_W];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        rxwm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_rst  (bus_rst),
            .wr       (reg_wr && (reg_wsel == SEL_W'(g))),
            .wr_count (reg_wdata[CNT_W-1:0]),
            .wr_stop  (reg_wdata[STOP_BIT]),
            .pulse    (out_done[g]),
            .rearm    (rearm[g]),
            .clr_cnt  (clr_cnt[g]),
            .clr_eot  (clr_eot[g]),
            .rdata    (all_regs[g*REG_W +: REG_W]),
            .cnt_irq  (cnt_irq[g]),
            .eot_irq  (eot_irq[g]),
            .nak_force(nak_force[g])
        );
    end

    rxwm_rdmux #(.NCH(NCH), .SEL_W(SEL_W)) u_rdmux (
        .regs (all_regs),
        .sel  (reg_rsel),
        .rdata(reg_rdata)
    );
endmodule

// File: rtl/rxwm_ctrl_chk.sv
module rxwm_ctrl_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_rst,
    input logic [NCH-1:0] out_done,
    input logic [NCH-1:0] rearm,
    input logic [NCH-1:0] cnt_irq,
    input logic [NCH-1:0] eot_irq,
    input logic [NCH-1:0] nak_force
);
    for (genvar i = 0; i < NCH; i++) begin : g_prop
        // R4: a new end-of-transfer flag comes with the count flag
        a_r4_eot_with_cnt: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eot_irq[i]) |-> cnt_irq[i]);

        // R5: a new end-of-transfer flag comes with NAK forcing
        a_r5_eot_forces_nak: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eot_irq[i]) |-> nak_force[i]);

        // R6: a halted channel stays halted without a re-enable or reset
        a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (nak_force[i] && !rearm[i] && !bus_rst) |=> nak_force[i]);

        // R3: the count flag only rises after a transaction pulse
        a_r3_cnt_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cnt_irq[i]) |-> $past(out_done[i]));

        // R8: a bus reset clears every per-channel output
        a_r8_bus_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rst |=> (!cnt_irq[i] && !eot_irq[i] && !nak_force[i]));
    end
endmodule

bind rxwm_ctrl rxwm_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .out_done (out_done),
    .rearm    (rearm),
    .cnt_irq  (cnt_irq),
    .eot_irq  (eot_irq),
    .nak_force(nak_force)
);

// File: tb/sim_rxwm_ctrl.sv
`timescale 1ns/1ps
module sim_rxwm_ctrl;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_wsel = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_rsel = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  out_done = '0, rearm = '0, clr_cnt = '0, clr_eot = '0;
    logic [2:0]  cnt_irq, eot_irq, nak_force;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rxwm_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
        .reg_wr(reg_wr), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
        .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .out_done(out_done), .rearm(rearm), .clr_cnt(clr_cnt), .clr_eot(clr_eot),
        .cnt_irq(cnt_irq), .eot_irq(eot_irq), .nak_force(nak_force)
    );

    // behavioural reference model
    int m_prog[NCH], m_rem[NCH], m_stop[NCH], m_halt[NCH], m_cf[NCH], m_ef[NCH];

    always @(posedge clk or negedge rst_n) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n || bus_rst) begin
                m_prog[c] = 0; m_rem[c] = 0; m_stop[c] = 0;
                m_halt[c] = 0; m_cf[c] = 0; m_ef[c] = 0;
            end else begin
                int was_halt, sc, se;
                was_halt = m_halt[c]; sc = 0; se = 0;
                if (reg_wr && reg_wsel == c) begin
                    m_prog[c] = reg_wdata[7:0];
                    m_rem[c]  = reg_wdata[7:0];
                    m_stop[c] = reg_wdata[15];
                end else if (was_halt && rearm[c]) begin
                    m_rem[c] = m_prog[c];
                end else if (!was_halt && out_done[c]) begin
                    if (m_rem[c] == 0) begin
                        sc = 1;
                        m_rem[c] = m_prog[c];
                        if (m_stop[c]) begin se = 1; m_halt[c] = 1; end
                    end else m_rem[c] = m_rem[c] - 1;
                end
                if (was_halt && rearm[c]) m_halt[c] = 0;
                m_cf[c] = (sc || (m_cf[c] && !clr_cnt[c])) ? 1 : 0;
                m_ef[c] = (se || (m_ef[c] && !clr_eot[c])) ? 1 : 0;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison, sampled away from the edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                chk($sformatf("R3 cnt_irq ch%0d", c), cnt_irq[c], m_cf[c]);
                chk($sformatf("R4 eot_irq ch%0d", c), eot_irq[c], m_ef[c]);
                chk($sformatf("R5 nak_force ch%0d", c), nak_force[c], m_halt[c]);
            end
            if (reg_rsel < NCH)
                chk("R7 reg_rdata model", reg_rdata,
                    (m_stop[reg_rsel] << 15) | m_rem[reg_rsel]);
        end
    end

    task automatic wr(int ch, int val);
        @(negedge clk); reg_wr = 1; reg_wsel = ch[1:0]; reg_wdata = val[15:0];
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic pulse(int ch);
        @(negedge clk); out_done[ch] = 1;
        @(negedge clk); out_done = '0;
    endtask
    task automatic rd(int ch, int exp, string tag);
        @(negedge clk); reg_rsel = ch[1:0];
        #5 chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8 reset state
        for (int c = 0; c < NCH; c++) rd(c, 0, "R8 reset register");
        chk("R8 reset flags", {cnt_irq, eot_irq, nak_force}, 0);

        // R2/R3/R7: watermark of 3 on ch0, stop clear
        wr(0, 16'h0002);
        rd(0, 2, "R7 read after write");
        pulse(0); pulse(0);
        rd(0, 0, "R7 remaining after two");
        chk("R3 no irq before watermark", cnt_irq[0], 0);
        pulse(0);
        @(negedge clk);
        chk("R3 irq at watermark", cnt_irq[0], 1);
        chk("R3 channel continues", nak_force[0], 0);
        rd(0, 2, "R3 reload");

        // R9 clear
        @(negedge clk); clr_cnt[0] = 1; @(negedge clk); clr_cnt = '0;
        chk("R9 cleared", cnt_irq[0], 0);

        // R11 ch1 unaffected so far
        rd(1, 0, "R11 ch1 untouched");

        // R4/R5/R10/R6: stop with watermark 2 on ch1
        wr(1, 16'h8001);
        pulse(1); pulse(1);
        @(negedge clk);
        chk("R4 eot set", eot_irq[1], 1);
        chk("R4 cnt set", cnt_irq[1], 1);
        chk("R5 nak set", nak_force[1], 1);
        pulse(1); pulse(1); pulse(1);
        rd(1, 16'h8001, "R10 ignored while halted");
        @(negedge clk); clr_cnt[1] = 1; @(negedge clk); clr_cnt = '0;
        pulse(1);
        chk("R10 no flag while halted", cnt_irq[1], 0);
        @(negedge clk); rearm[1] = 1; @(negedge clk); rearm = '0;
        chk("R6 rearmed", nak_force[1], 0);
        rd(1, 16'h8001, "R6 reload");
        @(negedge clk); rearm[0] = 1; @(negedge clk); rearm = '0;
        rd(0, 2, "R6 rearm no effect when running");

        // R2 watermark 1 on ch2, R9 set beats clear
        wr(2, 16'h0000);
        pulse(2);
        @(negedge clk);
        chk("R2 every transaction", cnt_irq[2], 1);
        @(negedge clk); out_done[2] = 1; clr_cnt[2] = 1;
        @(negedge clk); out_done = '0; clr_cnt = '0;
        chk("R9 set wins over clear", cnt_irq[2], 1);
        chk("R11 ch0 unaffected", cnt_irq[0], 0);

        // R12 write beats pulse
        @(negedge clk); reg_wr = 1; reg_wsel = 2'd2; reg_wdata = 16'h0005; out_done[2] = 1;
        @(negedge clk); reg_wr = 0; out_done = '0;
        rd(2, 5, "R12 write wins");

        // R1 reserved bits
        wr(2, 16'h7F33);
        rd(2, 16'h0033, "R1 reserved read zero");

        // R2 watermark 256 on ch0
        wr(0, 16'h00FF);
        for (int k = 0; k < 255; k++) pulse(0);
        chk("R2 no irq at 255", cnt_irq[0], 0);
        pulse(0);
        @(negedge clk);
        chk("R2 irq at 256", cnt_irq[0], 1);

        // R8 bus reset with a halted channel
        wr(1, 16'h8000);
        pulse(1);
        @(negedge clk);
        chk("R5 halted before bus reset", nak_force[1], 1);
        @(negedge clk); bus_rst = 1; @(negedge clk); bus_rst = 0;
        chk("R8 bus reset outputs", {cnt_irq, eot_irq, nak_force}, 0);
        for (int c = 0; c < NCH; c++) rd(c, 0, "R8 bus reset register");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule